// File: doc/BRIEF.md
# Housekeeping SPI Configuration Slave

This block lets an external host set the chip's critical analog and clock settings over a four-wire serial link that runs independently of the on-chip processor. The settings appear as parallel outputs that feed the oscillator, regulator, bandgap and PLL controls. The processor side can read these outputs but cannot change them. The slave also carries read-only identification fields, drives an interrupt line and an external reset request into the core, and has a pass-through mode. In that mode the serial data output becomes a live copy of one chosen internal signal, so the host can observe it.

The serial pins are sampled in the system clock domain through synchronizers. SCK edges are found there, which means the system clock must run at least four times faster than SCK. The link works in SPI mode 0 and sends the most significant bit first. A transaction is a command byte, then a byte that is an address or a tap selector, then data bytes. The address steps up by one after every data byte.

Top module: `hk_spi_slave`

## Requirements
- R1: After reset, the crystal oscillator, regulator, bandgap and PLL enables are 1. Every other setting is 0: the SPI config byte, DCO enable, PLL divider, PLL select, PLL trim, reset request and interrupt. spi_sdo is 0.
- R2: Command 0x80, then an address byte, then a data byte, writes the register. The outputs change by the next clock after the data byte's 8th SCK rise. Map: 0x00 cfg_word[7:0]. 0x01 enables {dco,pll,bgap,vreg,xtal} in bits 4..0. 0x02 {pll_sel[2:0],pll_div[4:0]}. 0x03..0x05 pll_trim bytes from low to high. 0x06 pll_trim[25:24] in bits 1..0. 0x07 {core_irq,ext_rst_req} in bits 1..0.
- R3: A write with several data bytes stores them at consecutive addresses.
- R4: Command 0x40, then an address, returns the register MSB-first on spi_sdo in the data bytes. spi_sdo changes only after SCK falling edges, and the address steps up by one after each byte.
- R5: Command 0xC0 returns the old register value on spi_sdo and writes the incoming byte to the same register.
- R6: Addresses 0x08..0x0B read as {4'h0,id_mfr[11:8]}, id_mfr[7:0], id_prod and {4'h0,id_rev}. Writes to these addresses change nothing.
- R7: Addresses 0x0C and above read as 0. Writes to them change no output.
- R8: A rising CSB discards a partly received byte and clears the bit counter. The partial byte is never written, and the next transaction starts fresh.
- R9: Command 0xC4, then a byte whose low SEL_W bits pick a tap, makes spi_sdo equal tap_in[selected] while CSB stays low. Once CSB rises, spi_sdo returns to 0.
- R10: Any other command byte causes no write, and spi_sdo stays 0 for the rest of the transaction.
- R11: core_rst is high while rst or ext_rst_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csb | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out or pass-through tap |
| tap_in | input | 2**SEL_W | Live internal signals for pass-through |
| id_mfr | input | 12 | Manufacturer identification |
| id_prod | input | 8 | Product identification |
| id_rev | input | 4 | Mask revision |
| cfg_word | output | 8 | Serial interface configuration byte |
| xtal_en | output | 1 | Crystal oscillator enable |
| vreg_en | output | 1 | Regulator enable |
| bgap_en | output | 1 | Bandgap enable |
| pll_en | output | 1 | PLL enable |
| dco_en | output | 1 | PLL DCO enable |
| pll_div | output | 5 | PLL divider |
| pll_sel | output | 3 | PLL source select |
| pll_trim | output | 26 | PLL trim |
| ext_rst_req | output | 1 | External reset request |
| core_irq | output | 1 | Interrupt to the processor |
| core_rst | output | 1 | Core reset, rst or reset request |

## Verification
A wrong bit counter or phase shows up as a data byte that is misaligned by one or more bits. It appears in the configuration outputs within one transaction, or on spi_sdo during the next read byte. A wrong address counter shows up in a burst read or write on its second byte. Stale pass-through state shows up as a nonzero spi_sdo a few clocks after CSB rises. Each of these faults therefore becomes visible at the ports within a single transaction.

// File: rtl/hk_spi_pkg.sv
package hk_spi_pkg;

    localparam logic [7:0] CMD_WR = 8'h80;
    localparam logic [7:0] CMD_RD = 8'h40;
    localparam logic [7:0] CMD_RW = 8'hC0;
    localparam logic [7:0] CMD_PT = 8'hC4;

    localparam logic [7:0] AD_CFG   = 8'h00;
    localparam logic [7:0] AD_ENA   = 8'h01;
    localparam logic [7:0] AD_PLL   = 8'h02;
    localparam logic [7:0] AD_TRIM0 = 8'h03;
    localparam logic [7:0] AD_TRIM1 = 8'h04;
    localparam logic [7:0] AD_TRIM2 = 8'h05;
    localparam logic [7:0] AD_TRIM3 = 8'h06;
    localparam logic [7:0] AD_CTRL  = 8'h07;
    localparam logic [7:0] AD_MFRH  = 8'h08;
    localparam logic [7:0] AD_MFRL  = 8'h09;
    localparam logic [7:0] AD_PROD  = 8'h0A;
    localparam logic [7:0] AD_REV   = 8'h0B;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_DATA, PH_SEL, PH_PASS, PH_SKIP
    } phase_t;

    typedef struct packed {
        logic       stb;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [7:0]  spi_cfg;
        logic [25:0] pll_trim;
        logic [4:0]  pll_div;
        logic [2:0]  pll_sel;
        logic        dco_en;
        logic        pll_en;
        logic        bgap_en;
        logic        vreg_en;
        logic        xtal_en;
        logic        irq;
        logic        ext_rst;
    } cfg_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c         = '0;
        c.pll_en  = 1'b1;
        c.bgap_en = 1'b1;
        c.vreg_en = 1'b1;
        c.xtal_en = 1'b1;
        return c;
    endfunction

    function automatic logic is_access_cmd(input logic [7:0] b);
        return (b == CMD_WR) || (b == CMD_RD) || (b == CMD_RW);
    endfunction

endpackage

// File: rtl/hk_sync.sv
module hk_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hk_spi_engine.sv
module hk_spi_engine
    import hk_spi_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_s,
    input  logic             csb_s,
    input  logic             sdi_s,
    input  logic [7:0]       rdata,
    output wr_req_t          wr,
    output logic [7:0]       addr,
    output logic             sdo_bit,
    output logic             pass_on,
    output logic [SEL_W-1:0] pass_sel,
    output logic             sck_fall,
    output logic [2:0]       bit_cnt
);
    logic       sck_q;
    logic       sck_rise;
    phase_t     phase;
    logic       rd_mode;
    logic       wr_mode;
    logic [6:0] shreg;
    logic [7:0] out_sh;
    logic [7:0] nb;

    assign sck_rise = sck_s & ~sck_q & ~csb_s;
    assign sck_fall = ~sck_s & sck_q & ~csb_s;
    assign nb       = {shreg, sdi_s};
    assign sdo_bit  = out_sh[7];
    assign pass_on  = (phase == PH_PASS);

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst || csb_s) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            shreg    <= '0;
            out_sh   <= '0;
            rd_mode  <= 1'b0;
            wr_mode  <= 1'b0;
            wr       <= '0;
            addr     <= '0;
            pass_sel <= '0;
        end else begin
            wr.stb <= 1'b0;
            if (sck_rise) begin
                shreg   <= nb[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_CMD: begin
                            if (nb == CMD_PT) begin
                                phase <= PH_SEL;
                            end else if (is_access_cmd(nb)) begin
                                phase   <= PH_ADDR;
                                wr_mode <= (nb == CMD_WR) || (nb == CMD_RW);
                                rd_mode <= (nb == CMD_RD) || (nb == CMD_RW);
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_ADDR: begin
                            addr  <= nb;
                            phase <= PH_DATA;
                        end
                        PH_DATA: begin
                            if (wr_mode) begin
                                wr.stb  <= 1'b1;
                                wr.addr <= addr;
                                wr.data <= nb;
                            end
                            addr <= addr + 8'd1;
                        end
                        PH_SEL: begin
                            pass_sel <= nb[SEL_W-1:0];
                            phase    <= PH_PASS;
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall) begin
                if (bit_cnt == 3'd0)
                    out_sh <= (phase == PH_DATA && rd_mode) ? rdata : 8'h00;
                else
                    out_sh <= {out_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/hk_cfg_regs.sv
module hk_cfg_regs
    import hk_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    input  logic [7:0] raddr,
    input  logic [11:0] id_mfr,
    input  logic [7:0] id_prod,
    input  logic [3:0] id_rev,
    output cfg_t       cfg,
    output logic [7:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_default();
        end else if (wr.stb) begin
            case (wr.addr)
                AD_CFG:   cfg.spi_cfg <= wr.data;
                AD_ENA:   {cfg.dco_en, cfg.pll_en, cfg.bgap_en, cfg.vreg_en, cfg.xtal_en} <= wr.data[4:0];
                AD_PLL:   {cfg.pll_sel, cfg.pll_div} <= wr.data;
                AD_TRIM0: cfg.pll_trim[7:0]   <= wr.data;
                AD_TRIM1: cfg.pll_trim[15:8]  <= wr.data;
                AD_TRIM2: cfg.pll_trim[23:16] <= wr.data;
                AD_TRIM3: cfg.pll_trim[25:24] <= wr.data[1:0];
                AD_CTRL:  {cfg.irq, cfg.ext_rst} <= wr.data[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (raddr)
            AD_CFG:   rdata = cfg.spi_cfg;
            AD_ENA:   rdata = {3'b000, cfg.dco_en, cfg.pll_en, cfg.bgap_en, cfg.vreg_en, cfg.xtal_en};
            AD_PLL:   rdata = {cfg.pll_sel, cfg.pll_div};
            AD_TRIM0: rdata = cfg.pll_trim[7:0];
            AD_TRIM1: rdata = cfg.pll_trim[15:8];
            AD_TRIM2: rdata = cfg.pll_trim[23:16];
            AD_TRIM3: rdata = {6'b0, cfg.pll_trim[25:24]};
            AD_CTRL:  rdata = {6'b0, cfg.irq, cfg.ext_rst};
            AD_MFRH:  rdata = {4'h0, id_mfr[11:8]};
            AD_MFRL:  rdata = id_mfr[7:0];
            AD_PROD:  rdata = id_prod;
            AD_REV:   rdata = {4'h0, id_rev};
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/hk_spi_slave.sv
module hk_spi_slave
    import hk_spi_pkg::*;
#(
    parameter  int SEL_W       = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int NTAPS       = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sck,
    input  logic             spi_csb,
    input  logic             spi_sdi,
    output logic             spi_sdo,
    input  logic [NTAPS-1:0] tap_in,
    input  logic [11:0]      id_mfr,
    input  logic [7:0]       id_prod,
    input  logic [3:0]       id_rev,
    output logic [7:0]       cfg_word,
    output logic             xtal_en,
    output logic             vreg_en,
    output logic             bgap_en,
    output logic             pll_en,
    output logic             dco_en,
    output logic [4:0]       pll_div,
    output logic [2:0]       pll_sel,
    output logic [25:0]      pll_trim,
    output logic             ext_rst_req,
    output logic             core_irq,
    output logic             core_rst
);
    logic [2:0]       pins_s;
    logic             sck_s, csb_s, sdi_s;
    wr_req_t          wr_req;
    logic [7:0]       reg_addr;
    logic [7:0]       reg_rdata;
    logic             sdo_bit;
    logic             pass_on;
    logic [SEL_W-1:0] pass_sel;
    logic             sck_fall;
    logic [2:0]       bit_cnt;
    cfg_t             cfg;

    hk_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sck, spi_csb, spi_sdi}),
        .q   (pins_s)
    );
    assign {sck_s, csb_s, sdi_s} = pins_s;

    hk_spi_engine #(.SEL_W(SEL_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .csb_s    (csb_s),
        .sdi_s    (sdi_s),
        .rdata    (reg_rdata),
        .wr       (wr_req),
        .addr     (reg_addr),
        .sdo_bit  (sdo_bit),
        .pass_on  (pass_on),
        .pass_sel (pass_sel),
        .sck_fall (sck_fall),
        .bit_cnt  (bit_cnt)
    );

    hk_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .raddr   (reg_addr),
        .id_mfr  (id_mfr),
        .id_prod (id_prod),
        .id_rev  (id_rev),
        .cfg     (cfg),
        .rdata   (reg_rdata)
    );

    assign spi_sdo     = pass_on ? tap_in[pass_sel] : sdo_bit;
    assign cfg_word    = cfg.spi_cfg;
    assign xtal_en     = cfg.xtal_en;
    assign vreg_en     = cfg.vreg_en;
    assign bgap_en     = cfg.bgap_en;
    assign pll_en      = cfg.pll_en;
    assign dco_en      = cfg.dco_en;
    assign pll_div     = cfg.pll_div;
    assign pll_sel     = cfg.pll_sel;
    assign pll_trim    = cfg.pll_trim;
    assign ext_rst_req = cfg.ext_rst;
    assign core_irq    = cfg.irq;
    assign core_rst    = rst | cfg.ext_rst;
endmodule

// File: rtl/hk_spi_slave_chk.sv
module hk_spi_slave_chk
    import hk_spi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       csb_s,
    input logic       sck_fall,
    input logic       wr_stb,
    input logic       pass_on,
    input logic [2:0] bit_cnt,
    input logic       spi_sdo,
    input logic       xtal_en,
    input logic       vreg_en,
    input logic       bgap_en,
    input logic       pll_en,
    input logic       ext_rst_req,
    input cfg_t       cfg
);
    // R1
    reset_enables_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (xtal_en && vreg_en && bgap_en && pll_en && !ext_rst_req));

    // R8
    cfg_change_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $past(wr_stb));

    // R8
    bitcnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(csb_s) |-> (bit_cnt == 3'd0));

    // R9
    pass_exit_chk: assert property (@(posedge clk) disable iff (rst)
        csb_s |=> !pass_on);

    // R4
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!pass_on && $past(!pass_on) && !$stable(spi_sdo)) |-> ($past(sck_fall) || $past(csb_s)));

    // R2
    write_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(!csb_s));
endmodule

bind hk_spi_slave hk_spi_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .csb_s       (csb_s),
    .sck_fall    (sck_fall),
    .wr_stb      (wr_req.stb),
    .pass_on     (pass_on),
    .bit_cnt     (bit_cnt),
    .spi_sdo     (spi_sdo),
    .xtal_en     (xtal_en),
    .vreg_en     (vreg_en),
    .bgap_en     (bgap_en),
    .pll_en      (pll_en),
    .ext_rst_req (ext_rst_req),
    .cfg         (cfg)
);

// File: tb/sim_hk_spi_slave.sv
module sim_hk_spi_slave;
    localparam int HALF = 8;
    localparam logic [11:0] MFR  = 12'hA5C;
    localparam logic [7:0]  PROD = 8'h3B;
    localparam logic [3:0]  REV  = 4'h7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic csb = 1'b1;
    logic sdi = 1'b0;
    logic [3:0] taps = 4'h0;

    logic        sdo;
    logic [7:0]  cfg_word;
    logic        xtal_en, vreg_en, bgap_en, pll_en, dco_en;
    logic [4:0]  pll_div;
    logic [2:0]  pll_sel;
    logic [25:0] pll_trim;
    logic        ext_rst_req, core_irq, core_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] mdl [0:7];

    always #2 clk = ~clk;

    hk_spi_slave u0 (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_csb(csb), .spi_sdi(sdi),
        .spi_sdo(sdo), .tap_in(taps), .id_mfr(MFR), .id_prod(PROD), .id_rev(REV),
        .cfg_word(cfg_word), .xtal_en(xtal_en), .vreg_en(vreg_en), .bgap_en(bgap_en),
        .pll_en(pll_en), .dco_en(dco_en), .pll_div(pll_div), .pll_sel(pll_sel),
        .pll_trim(pll_trim), .ext_rst_req(ext_rst_req), .core_irq(core_irq),
        .core_rst(core_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] amask(input int a);
        case (a)
            1: return 8'h1F;
            6, 7: return 8'h03;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        if (a < 8) return mdl[a];
        case (a)
            8:  return {4'h0, MFR[11:8]};
            9:  return MFR[7:0];
            10: return PROD;
            11: return {4'h0, REV};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_outs(input string req);
        check(req, cfg_word, mdl[0]);
        check(req, {dco_en, pll_en, bgap_en, vreg_en, xtal_en}, mdl[1][4:0]);
        check(req, {pll_sel, pll_div}, mdl[2]);
        check(req, pll_trim, {mdl[6][1:0], mdl[5], mdl[4], mdl[3]});
        check(req, {core_irq, ext_rst_req}, mdl[7][1:0]);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - n; i--) begin
            sdi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic open_tx();
        csb = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_tx();
        repeat (HALF) @(negedge clk);
        csb = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        logic [7:0] j;
        open_tx();
        xfer(8'h80, j);
        xfer(a[7:0], j);
        xfer(d, j);
        close_tx();
        if (a < 8) mdl[a] = d & amask(a);
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        logic [7:0] j;
        open_tx();
        xfer(8'h40, j);
        xfer(a[7:0], j);
        xfer(8'h00, d);
        close_tx();
    endtask

    initial begin
        logic [7:0] r;
        logic [7:0] j;
        for (int a = 0; a < 8; a++) mdl[a] = 8'h00;
        mdl[1] = 8'h0F;
        repeat (5) @(negedge clk);
        check("R11 core_rst in reset", core_rst, 1'b1);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check_outs("R1");
        check("R1 sdo", sdo, 1'b0);
        check("R11 core_rst idle", core_rst, 1'b0);

        // R2 / R4 sweep over writable registers
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 8; a++) begin
                wr(a, 8'((a * 59) + (p * 167) + 21));
                check_outs("R2");
            end
            for (int a = 0; a < 8; a++) begin
                rd(a, r);
                check("R4 readback", r, exp_rd(a));
            end
        end

        // R11 reset request and interrupt
        wr(7, 8'h01);
        check("R11 ext", {core_irq, ext_rst_req, core_rst}, 3'b011);
        wr(7, 8'h02);
        check("R11 irq", {core_irq, ext_rst_req, core_rst}, 3'b100);
        wr(7, 8'h00);

        // R3 burst write into trim
        open_tx();
        xfer(8'h80, j); xfer(8'h03, j);
        xfer(8'h11, j); xfer(8'h22, j); xfer(8'h33, j); xfer(8'hFF, j);
        close_tx();
        mdl[3] = 8'h11; mdl[4] = 8'h22; mdl[5] = 8'h33; mdl[6] = 8'h03;
        check("R3 trim", pll_trim, 26'h3332211);
        check_outs("R3");

        // R4 / R6 burst read of identification
        open_tx();
        xfer(8'h40, j); xfer(8'h08, j);
        for (int k = 8; k < 12; k++) begin
            xfer(8'h00, r);
            check("R4 R6 id burst", r, exp_rd(k));
        end
        close_tx();

        // R5 combined read/write
        wr(0, 8'h5A);
        open_tx();
        xfer(8'hC0, j); xfer(8'h00, j); xfer(8'hC3, r);
        close_tx();
        check("R5 old value", r, 8'h5A);
        mdl[0] = 8'hC3;
        check("R5 new value", cfg_word, 8'hC3);

        // R6 write to id ignored
        wr(10, 8'hFF);
        rd(10, r);
        check("R6 prod", r, PROD);
        check_outs("R6");

        // R7 unmapped
        for (int a = 12; a < 64; a++) begin
            rd(a, r);
            check("R7 unmapped read", r, 8'h00);
        end
        wr(32, 8'hFF);
        check_outs("R7");

        // R8 partial byte discarded
        open_tx();
        xfer(8'h80, j); xfer(8'h00, j); bits(8'hFF, 5, j);
        close_tx();
        check("R8 partial", cfg_word, mdl[0]);
        open_tx();
        bits(8'h80, 3, j);
        close_tx();
        wr(0, 8'h66);
        check("R8 fresh start", cfg_word, 8'h66);

        // R9 pass-through
        for (int s = 0; s < 4; s++) begin
            open_tx();
            xfer(8'hC4, j); xfer(8'(s), j);
            repeat (4) @(negedge clk);
            for (int v = 0; v < 16; v++) begin
                taps = 4'(v);
                @(negedge clk);
                check("R9 tap", sdo, taps[s]);
            end
            taps = 4'hF;
            close_tx();
            check("R9 exit", sdo, 1'b0);
        end
        taps = 4'h0;

        // R10 unknown command
        open_tx();
        xfer(8'h12, j); xfer(8'h00, r);
        check("R10 sdo byte1", r, 8'h00);
        xfer(8'h99, r);
        close_tx();
        check("R10 sdo byte2", r, 8'h00);
        check_outs("R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule